// File: doc/BRIEF.md
# Masked Slave Address Filter for a Multiprocessor Serial Receiver

This block sits behind a serial receiver that assembles 8-bit or 9-bit frames. It decides whether each completed frame should raise the receive-complete flag. It keeps two writable registers: the station's own address and a bit mask. When multiprocessor filtering is enabled in a 9-bit mode, an address frame (ninth bit set) is only accepted if it equals the own address on every bit the mask selects, or if it carries a 1 on every bit that is set in the OR of address and mask. The second test gives the broadcast match.

Each mask bit set to 1 makes the matching address bit take part in the comparison, and each mask bit set to 0 makes it don't-care. A master can therefore reach one station, a chosen group, or all stations. Both registers clear at reset. Every bit is then don't-care, so the filter accepts everything and behaves like a plain receiver. The shift-register mode never filters. The 8-bit mode with filtering enabled only asks for a valid stop bit.

The decision is registered. It shows up as a one-cycle pulse exactly one clock after the receiver's byte-complete strobe. Alongside it come the two raw comparison results.

Top module: `uart_addr_filter`

## Requirements
- R1: The own-address register is written and read at register address 0xA9 and the mask register at 0xB9. Both read back 0x00 after reset. A write to any other address changes neither, and reading an unmapped address returns 0x00.
- R2: `match_given` pulses for a frame when, for every bit i with mask[i]=1, rx_data[i] equals own-address[i].
- R3: `match_bcast` pulses for a frame when rx_data has a 1 at every bit position where (own-address OR mask) is 1.
- R4: With both registers at their reset value of zero, every frame in mode 2 or 3 with filtering enabled and ninth bit 1 is accepted, and both match outputs pulse.
- R5: In modes 2 and 3 (uart_mode = 2'b10 / 2'b11) with mp_en=1, `rx_accept` pulses only if rx_bit9=1 and at least one of the given or broadcast matches holds.
- R6: With mp_en=0, every frame is accepted in every mode.
- R7: In mode 0 (uart_mode = 2'b00), every frame is accepted whatever mp_en and rx_bit9 are.
- R8: In mode 1 (uart_mode = 2'b01) with mp_en=1, `rx_accept` equals rx_bit9 (the received stop bit) and does not depend on the address registers.
- R9: The outputs pulse high for exactly the one clock after a cycle with rx_valid=1, and are low in every other cycle.
- R10: A register write in the same cycle as rx_valid takes effect only for later frames. The frame in that cycle is compared against the old register values.
- R11: Own address 0xC0 with mask 0xFD accepts 0xC0 and 0xC2 and rejects 0xC1. Own address 0xE0 with mask 0xF9 accepts 0xE6 and 0xE4 and rejects 0xE3 (mode 3, mp_en=1, ninth bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the addressed register (combinational) |
| rx_valid | input | 1 | Receiver byte-complete strobe |
| rx_data | input | DW | Received byte |
| rx_bit9 | input | 1 | Ninth bit in 9-bit modes, stop bit in mode 1 |
| uart_mode | input | 2 | Receiver mode 0..3 |
| mp_en | input | 1 | Multiprocessor filtering enable |
| rx_accept | output | 1 | Pulse: raise the receive-complete flag for this frame |
| match_given | output | 1 | Pulse: frame hit the masked own address |
| match_bcast | output | 1 | Pulse: frame hit the broadcast address |

## Verification
The bench targets the worked address examples and the all-zero reset state. A filter that treats the mask the wrong way round, or builds the broadcast from AND instead of OR, rejects frames there that should pass. It also hits writes that coincide with the byte strobe: a design that compares against the freshly written value would flip the decision for that frame. Random frames over every mode, filter setting and ninth-bit value show any mode-0 or mode-1 path that wrongly consults the address registers, and any output that is not a single pulse one clock late.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

   typedef enum logic [1:0] {
      UAF_SHIFT  = 2'b00,
      UAF_8BIT   = 2'b01,
      UAF_9BIT_F = 2'b10,
      UAF_9BIT_V = 2'b11
   } uaf_mode_e;

   function automatic logic uaf_is_nine(input uaf_mode_e m);
      return (m == UAF_9BIT_F) || (m == UAF_9BIT_V);
   endfunction

endpackage

// File: rtl/uaf_regs.sv
module uaf_regs #(
   parameter int DW       = 8,
   parameter int REG_AW   = 8,
   parameter int ADDR_LOC = 'hA9,
   parameter int MASK_LOC = 'hB9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_sel,
   input  logic [DW-1:0]     wr_val,
   output logic [DW-1:0]     rd_val,
   output logic [DW-1:0]     own_q,
   output logic [DW-1:0]     msk_q
);

   localparam logic [REG_AW-1:0] SEL_OWN = REG_AW'(ADDR_LOC);
   localparam logic [REG_AW-1:0] SEL_MSK = REG_AW'(MASK_LOC);

   logic hit_own;
   logic hit_msk;

   assign hit_own = (wr_sel == SEL_OWN);
   assign hit_msk = (wr_sel == SEL_MSK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= '0;
         msk_q <= '0;
      end else if (wr_en) begin
         if (hit_own) own_q <= wr_val;
         if (hit_msk) msk_q <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      if (hit_own)      rd_val = own_q;
      else if (hit_msk) rd_val = msk_q;
   end

endmodule

// File: rtl/uaf_cmp.sv
module uaf_cmp #(
   parameter int DW       = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [DW-1:0] frame,
   input  logic [DW-1:0] own,
   input  logic [DW-1:0] msk,
   output logic          hit_given,
   output logic          hit_bcast
);

   logic [DW-1:0] bit_ok_given;
   logic [DW-1:0] bit_ok_bcast;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      // a masked-out bit always agrees
      assign bit_ok_given[i] = ~msk[i] | ~(frame[i] ^ own[i]);
      // a zero in (own | mask) is don't-care, a one needs a one
      assign bit_ok_bcast[i] = ~(own[i] | msk[i]) | frame[i];
   end

   assign hit_given = &bit_ok_given;

   if (BCAST_EN) begin : g_bcast
      assign hit_bcast = &bit_ok_bcast;
   end else begin : g_no_bcast
      logic unused_bcast;
      assign unused_bcast = &bit_ok_bcast;
      assign hit_bcast    = 1'b0;
   end

endmodule

// File: rtl/uaf_decide.sv
module uaf_decide
   import uaf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  uaf_mode_e mode,
   input  logic      mp_on,
   input  logic      bit9,
   input  logic      hit_given,
   input  logic      hit_bcast,
   output logic      take_q,
   output logic      given_q,
   output logic      bcast_q
);

   logic take_d;

   always_comb begin
      unique case (mode)
         UAF_SHIFT: take_d = 1'b1;
         UAF_8BIT:  take_d = ~mp_on | bit9;
         default:   take_d = ~mp_on | (bit9 & (hit_given | hit_bcast));
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q  <= 1'b0;
         given_q <= 1'b0;
         bcast_q <= 1'b0;
      end else begin
         take_q  <= strobe & take_d;
         given_q <= strobe & hit_given;
         bcast_q <= strobe & hit_bcast;
      end
   end

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
   import uaf_pkg::*;
#(
   parameter int DW       = 8,
   parameter int REG_AW   = 8,
   parameter int ADDR_LOC = 'hA9,
   parameter int MASK_LOC = 'hB9,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              rx_valid,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_bit9,
   input  logic [1:0]        uart_mode,
   input  logic              mp_en,
   output logic              rx_accept,
   output logic              match_given,
   output logic              match_bcast
);

   if (DW < 1) begin : g_bad_dw
      $error("uart_addr_filter: DW must be at least 1");
   end
   if (REG_AW < 1 || REG_AW > 30) begin : g_bad_aw
      $error("uart_addr_filter: REG_AW out of range");
   end
   if (ADDR_LOC == MASK_LOC) begin : g_bad_loc
      $error("uart_addr_filter: register locations collide");
   end
   if (ADDR_LOC >= (1 << REG_AW) || MASK_LOC >= (1 << REG_AW)) begin : g_bad_fit
      $error("uart_addr_filter: register location exceeds REG_AW");
   end

   logic [DW-1:0] addr_q;
   logic [DW-1:0] mask_q;
   logic          hit_given;
   logic          hit_bcast;

   uaf_regs #(
      .DW       (DW),
      .REG_AW   (REG_AW),
      .ADDR_LOC (ADDR_LOC),
      .MASK_LOC (MASK_LOC)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_we),
      .wr_sel (reg_addr),
      .wr_val (reg_wdata),
      .rd_val (reg_rdata),
      .own_q  (addr_q),
      .msk_q  (mask_q)
   );

   uaf_cmp #(
      .DW       (DW),
      .BCAST_EN (BCAST_EN)
   ) u_cmp (
      .frame     (rx_data),
      .own       (addr_q),
      .msk       (mask_q),
      .hit_given (hit_given),
      .hit_bcast (hit_bcast)
   );

   uaf_decide u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (rx_valid),
      .mode      (uaf_mode_e'(uart_mode)),
      .mp_on     (mp_en),
      .bit9      (rx_bit9),
      .hit_given (hit_given),
      .hit_bcast (hit_bcast),
      .take_q    (rx_accept),
      .given_q   (match_given),
      .bcast_q   (match_bcast)
   );

endmodule

// File: rtl/uaf_checks.sv
module uaf_checks #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic [DW-1:0] rx_data,
   input logic          rx_bit9,
   input logic [1:0]    uart_mode,
   input logic          mp_en,
   input logic [DW-1:0] addr_q,
   input logic          rx_accept,
   input logic          match_given,
   input logic          match_bcast
);

   AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_accept || match_given || match_bcast) |-> $past(rx_valid)); // R9

   AST_SHIFT_MODE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && uart_mode == 2'b00) |=> rx_accept); // R7

   AST_FILTER_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !mp_en) |=> rx_accept); // R6

   AST_NINTH_BIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && uart_mode[1] && mp_en && !rx_bit9) |=> !rx_accept); // R5

   AST_ADDR_HIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && uart_mode[1] && mp_en && rx_bit9)
      |=> (rx_accept == (match_given || match_bcast))); // R5

   AST_STOP_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && uart_mode == 2'b01 && mp_en) |=> (rx_accept == $past(rx_bit9))); // R8

   AST_SELF_ADDR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_data == addr_q) |=> match_given); // R2

   AST_ALL_ONES_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (&rx_data)) |=> match_bcast); // R3

endmodule

bind uart_addr_filter uaf_checks #(.DW(DW)) u_uaf_checks (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_valid    (rx_valid),
   .rx_data     (rx_data),
   .rx_bit9     (rx_bit9),
   .uart_mode   (uart_mode),
   .mp_en       (mp_en),
   .addr_q      (addr_q),
   .rx_accept   (rx_accept),
   .match_given (match_given),
   .match_bcast (match_bcast)
);

// File: tb/uart_addr_filter_bench.sv
module uart_addr_filter_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] LOC_ADDR = 8'hA9;
   localparam logic [7:0] LOC_MASK = 8'hB9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_bit9 = 1'b0;
   logic [1:0] uart_mode = '0;
   logic       mp_en = 1'b0;
   logic       rx_accept;
   logic       match_given;
   logic       match_bcast;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] m_addr = '0;
   logic [7:0] m_mask = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_addr_filter u_uart_addr_filter (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .rx_valid (rx_valid), .rx_data (rx_data), .rx_bit9 (rx_bit9),
      .uart_mode (uart_mode), .mp_en (mp_en),
      .rx_accept (rx_accept), .match_given (match_given), .match_bcast (match_bcast)
   );

   function automatic logic f_given(logic [7:0] d, logic [7:0] a, logic [7:0] m);
      return ((d ^ a) & m) == 8'h00;
   endfunction

   function automatic logic f_bcast(logic [7:0] d, logic [7:0] a, logic [7:0] m);
      return ((~d) & (a | m)) == 8'h00;
   endfunction

   function automatic logic f_take(logic [1:0] md, logic mp, logic b9, logic g, logic b);
      if (md == 2'b00) return 1'b1;
      if (!mp) return 1'b1;
      if (md == 2'b01) return b9;
      return b9 & (g | b);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driven after a negedge; the next negedge follows the register edge
   task automatic reg_write(logic [7:0] loc, logic [7:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = loc; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
      if (loc == LOC_ADDR) m_addr = val;
      if (loc == LOC_MASK) m_mask = val;
   endtask

   task automatic reg_read(string req, logic [7:0] loc, logic [7:0] exp);
      @(negedge clk);
      reg_addr = loc;
      #1 check(req, reg_rdata, exp, "register read");
   endtask

   // one frame; outputs checked one clock later, then the idle cycle after it
   task automatic frame(string req, logic [7:0] d, logic b9, logic [1:0] md, logic mp);
      logic g, b, t;
      g = f_given(d, m_addr, m_mask);
      b = f_bcast(d, m_addr, m_mask);
      t = f_take(md, mp, b9, g, b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_bit9 = b9; uart_mode = md; mp_en = mp;
      @(negedge clk);
      rx_valid = 1'b0;
      check(req, rx_accept, t, "accept");
      check("R2", match_given, g, "given");
      check("R3", match_bcast, b, "bcast");
      @(negedge clk);
      check("R9", {rx_accept, match_given, match_bcast}, 3'b000, "idle outputs");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd5417));
      repeat (3) @(negedge clk);
      check("R9", {rx_accept, match_given, match_bcast}, 3'b000, "outputs in reset");
      rst_n = 1'b1;
      // R1 reset values and decode
      reg_read("R1", LOC_ADDR, 8'h00);
      reg_read("R1", LOC_MASK, 8'h00);
      // R4 filter open after reset
      frame("R4", 8'h5A, 1'b1, 2'b11, 1'b1);
      frame("R4", 8'h00, 1'b1, 2'b10, 1'b1);
      // R1 writes and ignored write
      reg_write(LOC_ADDR, 8'h3C);
      reg_write(LOC_MASK, 8'hC3);
      reg_read("R1", LOC_ADDR, 8'h3C);
      reg_read("R1", LOC_MASK, 8'hC3);
      reg_write(8'hAA, 8'hFF);
      reg_read("R1", LOC_ADDR, 8'h3C);
      reg_read("R1", LOC_MASK, 8'hC3);
      reg_read("R1", 8'h10, 8'h00);
      // R11 worked examples
      reg_write(LOC_ADDR, 8'hC0);
      reg_write(LOC_MASK, 8'hFD);
      frame("R11", 8'hC0, 1'b1, 2'b11, 1'b1);
      frame("R11", 8'hC2, 1'b1, 2'b11, 1'b1);
      frame("R11", 8'hC1, 1'b1, 2'b11, 1'b1);
      check("R11", rx_accept, 1'b0, "C1 stays rejected");
      reg_write(LOC_ADDR, 8'hE0);
      reg_write(LOC_MASK, 8'hF9);
      frame("R11", 8'hE6, 1'b1, 2'b11, 1'b1);
      frame("R11", 8'hE4, 1'b1, 2'b11, 1'b1);
      frame("R11", 8'hE3, 1'b1, 2'b11, 1'b1);
      frame("R3",  8'hFF, 1'b1, 2'b10, 1'b1);
      // R5 ninth bit clear rejects even a hit
      frame("R5", 8'hE6, 1'b0, 2'b11, 1'b1);
      // R6, R7, R8 on a non-matching byte
      frame("R6", 8'h13, 1'b0, 2'b11, 1'b0);
      frame("R7", 8'h13, 1'b0, 2'b00, 1'b1);
      frame("R8", 8'h13, 1'b1, 2'b01, 1'b1);
      frame("R8", 8'hE6, 1'b0, 2'b01, 1'b1);
      // R10 write coinciding with the strobe
      begin
         logic g, b;
         g = f_given(8'h25, m_addr, m_mask);
         b = f_bcast(8'h25, m_addr, m_mask);
         @(negedge clk);
         reg_we = 1'b1; reg_addr = LOC_MASK; reg_wdata = 8'h00;
         rx_valid = 1'b1; rx_data = 8'h25; rx_bit9 = 1'b1; uart_mode = 2'b11; mp_en = 1'b1;
         @(negedge clk);
         reg_we = 1'b0; rx_valid = 1'b0; m_mask = 8'h00;
         check("R10", rx_accept, g | b, "accept with old mask");
         check("R10", match_given, g, "given with old mask");
         frame("R10", 8'h25, 1'b1, 2'b11, 1'b1);
      end
      // random mix
      for (int k = 0; k < 400; k++) begin
         if (k % 25 == 0) begin
            reg_write(LOC_ADDR, 8'($urandom));
            reg_write(LOC_MASK, 8'($urandom));
         end
         begin
            logic [7:0] d;
            d = (k % 3 == 0) ? (m_addr ^ (8'($urandom) & ~m_mask)) : 8'($urandom);
            frame("R5", d, 1'($urandom), 2'($urandom), 1'($urandom));
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule